// File: doc/BRIEF.md
# Audio Output Routing and Power-Mode Controller

This block turns the control fields of a small audio subsystem into the enable and mix-select lines that drive its analog section. It takes a four-bit routing code, an earpiece-bypass request, a right-headphone mute, a gain-amplifier power-save bit, a global power bit and a turn-on-speed bit. From these it works out three things: which sources each of the three output summers (speaker, left headphone, right headphone) adds together, which input gain amplifiers stay powered, and which output stages are enabled.

The controls take effect in a fixed order. Global power overrides everything. The bypass request comes next, and the routing code comes last. A right-headphone mute applies on top of whichever route is active. When power is switched on, the output stages stay off until a selectable number of millisecond ticks has been counted. After that a ready flag is raised. Changing the route while powered takes effect one clock later and does not start a new delay.

All outputs are registered, so each output changes one clock after the inputs that drive it.

Top module: `audio_route_ctrl`

## Requirements
- R1: Routing bit 0 selects the mono source for the speaker, and routing bit 1 selects both left and right for the speaker. The speaker stage is enabled when either bit is set. In every select vector, bit 0 is mono, bit 1 is left and bit 2 is right.
- R2: Routing bit 2 selects mono (at half level) on both headphones. Routing bit 3 selects left on the left headphone and right on the right headphone. A headphone stage is enabled when either bit is set.
- R3: Routing code 0000 clears every select and every output-stage enable.
- R4: When the bypass request is set, the routing code is ignored. All speaker and headphone selects and enables go to 0, and only the bypass stage enable is 1.
- R5: When the right-headphone mute is set, the right-headphone select and enable are 0 whatever the route is. The mute has no effect on the other outputs.
- R6: The gain-enable vector uses the same bit order as the selects. With power-save clear, all three gain amplifiers are on while powered. With power-save set, only the amplifiers whose source feeds an enabled output are on, so route 0001, 0100 and 0101 give 001.
- R7: While global power is off, and in the reset state, every select, gain enable, stage enable and ready output is 0 one clock later.
- R8: After power turns on, ready and all stage enables stay 0 until 27 ticks (normal) or 15 ticks (fast) have been counted. They become 1 on the clock that takes the last tick. Turning power off clears the count.
- R9: A route change while ready is reflected on the outputs one clock later, and ready stays 1.
- R10: The speed bit is sampled only while power is off. Changing it during a count does not alter that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| route_code | input | 4 | Routing code; bit0 spk mono, bit1 spk stereo, bit2 hp mono, bit3 hp stereo |
| bypass_req | input | 1 | Earpiece bypass request |
| hpr_mute | input | 1 | Right headphone shutdown |
| gain_save | input | 1 | Power down unused gain amplifiers |
| power_on | input | 1 | Global power enable |
| fast_start | input | 1 | 1 selects the short turn-on delay |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| spk_sel | output | 3 | Speaker summer source select {R,L,M} |
| hpl_sel | output | 3 | Left headphone summer source select {R,L,M} |
| hpr_sel | output | 3 | Right headphone summer source select {R,L,M} |
| gain_en | output | 3 | Input gain amplifier enables {R,L,M} |
| spk_en | output | 1 | Speaker output stage enable |
| hpl_en | output | 1 | Left headphone stage enable |
| hpr_en | output | 1 | Right headphone stage enable |
| byp_en | output | 1 | Earpiece bypass stage enable |
| ready | output | 1 | Turn-on delay complete |

## Verification
The properties assume that the control inputs are level signals sampled on the clock, and that `ms_tick` is a single-cycle pulse with no fixed relation to any control change. The stimulus changes inputs only just after a rising edge. It holds `ms_tick` high for exactly one cycle and leaves at least one idle cycle before the next tick. It sets the speed bit while power is off, at least one clock before power rises. Only the deliberate mid-count toggle breaks that rule, and it is there to show that the bit is ignored once counting has started.

// File: rtl/audio_route_pkg.sv
// Shared constants for the routing controller: source bit positions and the
// select vector type. Assumes exactly three sources: mono, left and right.
package audio_route_pkg;
    localparam int NSRC    = 3;
    localparam int SRC_M   = 0;
    localparam int SRC_L   = 1;
    localparam int SRC_R   = 2;
    localparam int CODE_W  = 4;
    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/route_decode.sv
// Combinational decode of the routing code, the bypass request and the right
// mute into summer selects, output-stage requests and gain amplifier enables.
// Assumes that power gating and registering are done by the parent.
module route_decode
    import audio_route_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              bypass,
    input  logic              rmute,
    input  logic              save,
    output src_vec_t          spk_s,
    output src_vec_t          hpl_s,
    output src_vec_t          hpr_s,
    output src_vec_t          gain_s,
    output logic [3:0]        stage_s
);
    logic spk_m, spk_st, hp_m, hp_st;
    src_vec_t used;

    // Split the code into its four route requests; a bypass request masks them all.
    always_comb begin
        spk_m  = code[0] & ~bypass;
        spk_st = code[1] & ~bypass;
        hp_m   = code[2] & ~bypass;
        hp_st  = code[3] & ~bypass;
    end

    // Build the source selects for each summer.
    always_comb begin
        spk_s = '0;
        hpl_s = '0;
        hpr_s = '0;
        spk_s[SRC_M] = spk_m;
        spk_s[SRC_L] = spk_st;
        spk_s[SRC_R] = spk_st;
        hpl_s[SRC_M] = hp_m;
        hpl_s[SRC_L] = hp_st;
        hpr_s[SRC_M] = hp_m & ~rmute;
        hpr_s[SRC_R] = hp_st & ~rmute;
    end

    // Output stage requests in the order {bypass, hpr, hpl, spk}.
    always_comb begin
        stage_s[0] = spk_m | spk_st;
        stage_s[1] = hp_m | hp_st;
        stage_s[2] = (hp_m | hp_st) & ~rmute;
        stage_s[3] = bypass;
    end

    // A source counts as used when any enabled output selects it.
    assign used = spk_s | hpl_s | hpr_s;

    // Per-source gain enable: everything stays on unless power-save is set.
    for (genvar g = 0; g < NSRC; g++) begin : g_gain
        assign gain_s[g] = save ? used[g] : 1'b1;
    end
endmodule

// File: rtl/startup_timer.sv
// Counts millisecond ticks after power comes on and raises ready once the
// selected delay has elapsed. The speed bit is captured only while power is
// off. Assumes that ms_tick is a one-cycle pulse.
module startup_timer #(
    parameter int NORMAL_MS = 27,
    parameter int FAST_MS   = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr,
    input  logic fast,
    input  logic tick,
    output logic rdy
);
    localparam int CW = $clog2(NORMAL_MS + 1);
    localparam logic [CW-1:0] NORM_T = CW'(NORMAL_MS);
    localparam logic [CW-1:0] FAST_T = CW'(FAST_MS);

    logic [CW-1:0] cnt_q, tgt_q;

    // Capture the target while off; count ticks while on until ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgt_q <= NORM_T;
            rdy   <= 1'b0;
        end else if (!pwr) begin
            cnt_q <= '0;
            tgt_q <= fast ? FAST_T : NORM_T;
            rdy   <= 1'b0;
        end else if (!rdy && tick) begin
            if (cnt_q == tgt_q - 1'b1) rdy <= 1'b1;
            else                       cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/audio_route_ctrl.sv
// Top of the routing and power-mode controller. It registers the decoded
// selects and gain enables under global power, and gates the output-stage
// enables with the turn-on ready flag. Every output lags its inputs by one clock.
module audio_route_ctrl
    import audio_route_pkg::*;
#(
    parameter int NORMAL_MS = 27,
    parameter int FAST_MS   = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  route_code,
    input  logic        bypass_req,
    input  logic        hpr_mute,
    input  logic        gain_save,
    input  logic        power_on,
    input  logic        fast_start,
    input  logic        ms_tick,
    output logic [2:0]  spk_sel,
    output logic [2:0]  hpl_sel,
    output logic [2:0]  hpr_sel,
    output logic [2:0]  gain_en,
    output logic        spk_en,
    output logic        hpl_en,
    output logic        hpr_en,
    output logic        byp_en,
    output logic        ready
);
    src_vec_t   spk_d, hpl_d, hpr_d, gain_d;
    logic [3:0] stage_d, stage_q;
    src_vec_t   spk_q, hpl_q, hpr_q, gain_q;

    route_decode u_dec (
        .code    (route_code),
        .bypass  (bypass_req),
        .rmute   (hpr_mute),
        .save    (gain_save),
        .spk_s   (spk_d),
        .hpl_s   (hpl_d),
        .hpr_s   (hpr_d),
        .gain_s  (gain_d),
        .stage_s (stage_d)
    );

    startup_timer #(.NORMAL_MS(NORMAL_MS), .FAST_MS(FAST_MS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .pwr   (power_on),
        .fast  (fast_start),
        .tick  (ms_tick),
        .rdy   (ready)
    );

    // Register the decoded state, cleared whenever global power is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !power_on) begin
            spk_q   <= '0;
            hpl_q   <= '0;
            hpr_q   <= '0;
            gain_q  <= '0;
            stage_q <= '0;
        end else begin
            spk_q   <= spk_d;
            hpl_q   <= hpl_d;
            hpr_q   <= hpr_d;
            gain_q  <= gain_d;
            stage_q <= stage_d;
        end
    end

    // Drive the ports; output stages wait for the turn-on delay.
    always_comb begin
        spk_sel = spk_q;
        hpl_sel = hpl_q;
        hpr_sel = hpr_q;
        gain_en = gain_q;
        spk_en  = stage_q[0] & ready;
        hpl_en  = stage_q[1] & ready;
        hpr_en  = stage_q[2] & ready;
        byp_en  = stage_q[3] & ready;
    end
endmodule

// File: rtl/audio_route_ctrl_chk.sv
// Checker for the routing controller, bound to every instance of the top.
// Assumes synchronous active-low reset; it observes ports only.
module audio_route_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hpr_mute,
    input logic       power_on,
    input logic [2:0] spk_sel,
    input logic [2:0] hpr_sel,
    input logic [2:0] gain_en,
    input logic       spk_en,
    input logic       hpl_en,
    input logic       hpr_en,
    input logic       byp_en,
    input logic       ready
);
    assert_spk_has_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
        spk_en |-> (spk_sel != 3'b000));

    assert_bypass_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byp_en |-> (!spk_en && !hpl_en && !hpr_en));

    assert_right_muted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hpr_mute |=> (!hpr_en && hpr_sel == 3'b000));

    assert_power_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !power_on |=> (!ready && gain_en == 3'b000 && spk_sel == 3'b000));

    assert_stage_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> $countones({spk_en, hpl_en, hpr_en, byp_en}) == 0);

    assert_ready_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && power_on) |=> ready);
endmodule

bind audio_route_ctrl audio_route_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hpr_mute (hpr_mute),
    .power_on (power_on),
    .spk_sel  (spk_sel),
    .hpr_sel  (hpr_sel),
    .gain_en  (gain_en),
    .spk_en   (spk_en),
    .hpl_en   (hpl_en),
    .hpr_en   (hpr_en),
    .byp_en   (byp_en),
    .ready    (ready)
);

// File: tb/audio_route_ctrl_tb_top.sv
// Self-checking bench: a routing vector table walked by one loop, then
// directed tests for reset, turn-on delay, speed capture and power-off.
module audio_route_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] route_code = '0;
    logic       bypass_req = 0, hpr_mute = 0, gain_save = 0;
    logic       power_on = 0, fast_start = 0, ms_tick = 0;
    logic [2:0] spk_sel, hpl_sel, hpr_sel, gain_en;
    logic       spk_en, hpl_en, hpr_en, byp_en, ready;
    int         checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    audio_route_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .route_code(route_code),
        .bypass_req(bypass_req), .hpr_mute(hpr_mute), .gain_save(gain_save),
        .power_on(power_on), .fast_start(fast_start), .ms_tick(ms_tick),
        .spk_sel(spk_sel), .hpl_sel(hpl_sel), .hpr_sel(hpr_sel),
        .gain_en(gain_en), .spk_en(spk_en), .hpl_en(hpl_en),
        .hpr_en(hpr_en), .byp_en(byp_en), .ready(ready)
    );

    // Layout: [22:19] code, [18] bypass, [17] rmute, [16] save,
    // [15:13] spk, [12:10] hpl, [9:7] hpr, [6:4] gain, [3:0] {spk,hpl,hpr,byp} en
    localparam int NV = 13;
    localparam logic [22:0] VEC [NV] = '{
        {4'b0000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b111, 4'b0000},
        {4'b0001, 3'b001, 3'b001, 3'b000, 3'b000, 3'b001, 4'b1000},
        {4'b0100, 3'b001, 3'b000, 3'b001, 3'b001, 3'b001, 4'b0110},
        {4'b0101, 3'b001, 3'b001, 3'b001, 3'b001, 3'b001, 4'b1110},
        {4'b0010, 3'b001, 3'b110, 3'b000, 3'b000, 3'b110, 4'b1000},
        {4'b1000, 3'b001, 3'b000, 3'b010, 3'b100, 3'b110, 4'b0110},
        {4'b1111, 3'b001, 3'b111, 3'b011, 3'b101, 3'b111, 4'b1110},
        {4'b1100, 3'b011, 3'b000, 3'b011, 3'b000, 3'b011, 4'b0100},
        {4'b1010, 3'b000, 3'b110, 3'b010, 3'b100, 3'b111, 4'b1110},
        {4'b1111, 3'b101, 3'b000, 3'b000, 3'b000, 3'b000, 4'b0001},
        {4'b1111, 3'b100, 3'b000, 3'b000, 3'b000, 3'b111, 4'b0001},
        {4'b0011, 3'b011, 3'b111, 3'b000, 3'b000, 3'b111, 4'b1000},
        {4'b1000, 3'b011, 3'b000, 3'b010, 3'b000, 3'b010, 4'b0100}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1'b1; step(); ms_tick = 1'b0; step();
        end
    endtask

    task automatic all_off(input string tag);
        chk(tag, {spk_sel, hpl_sel, hpr_sel, gain_en, spk_en, hpl_en, hpr_en, byp_en, ready}, '0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1;
        step(); step();
        all_off("R7 reset state");
        rst_n = 1'b1; step();
        all_off("R7 powered off after reset");

        // R8 normal delay of 27 ticks
        route_code = 4'b0001; step();
        power_on = 1'b1; step();
        chk("R6 gains on before ready", gain_en, 3'b111);
        chk("R8 spk held off", spk_en, 1'b0);
        tick_n(26);
        chk("R8 not ready after 26", ready, 1'b0);
        chk("R8 spk off after 26", spk_en, 1'b0);
        tick_n(1);
        chk("R8 ready after 27", ready, 1'b1);
        chk("R8 spk on after 27", spk_en, 1'b1);

        // Routing table: R1 R2 R3 R4 R5 R6, with R9 latency and ready hold
        for (int i = 0; i < NV; i++) begin
            {route_code, bypass_req, hpr_mute, gain_save} = VEC[i][22:16];
            step();
            chk($sformatf("R1 R2 R3 R4 R5 R6 vec %0d", i),
                {spk_sel, hpl_sel, hpr_sel, gain_en, spk_en, hpl_en, hpr_en, byp_en},
                VEC[i][15:0]);
            chk($sformatf("R9 ready kept vec %0d", i), ready, 1'b1);
        end

        // R7 power off clears everything one clock later
        bypass_req = 0; hpr_mute = 0; gain_save = 0; route_code = 4'b1111;
        power_on = 1'b0; step();
        all_off("R7 power off");
        tick_n(2);
        all_off("R7 ticks while off");

        // R10 fast delay captured while off; mid-count toggle ignored
        fast_start = 1'b1; step();
        power_on = 1'b1; step();
        tick_n(7);
        fast_start = 1'b0;
        tick_n(7);
        chk("R10 not ready after 14", ready, 1'b0);
        tick_n(1);
        chk("R10 ready after 15", ready, 1'b1);
        chk("R10 hpl on after 15", hpl_en, 1'b1);

        // R8 power cycle clears the count
        power_on = 1'b0; fast_start = 1'b1; step();
        power_on = 1'b1; step();
        tick_n(10);
        power_on = 1'b0; step();
        power_on = 1'b1; step();
        tick_n(14);
        chk("R8 count restarted", ready, 1'b0);
        tick_n(1);
        chk("R8 ready after restart", ready, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule